// File: doc/BRIEF.md
# Expansion-Bus I/O Wait-State Generator

This block produces the two cycle-timing replies that a peripheral on an 8/16-bit expansion bus gives the host. It watches the address lines, the DMA address-enable qualifier and the active-low I/O read and write strobes. All of these are synchronous to the bus clock. When the decoded I/O window is selected and a strobe is active, the block does one of two things. It can pull the channel-ready line low for a configured number of bus clocks, which stretches the host's cycle. For a fast peripheral it can instead pull the no-wait-state line low, which lets the host end the cycle early.

Both replies are open-drain. Each one is modelled as a drive-low enable plus a level that is always zero, so a pad cell can only sink the line or release it. The number of wait clocks comes from a static configuration input, which stands in for board jumpers. The block clamps that number to a hard ceiling so the ready line is never held low past the bus limit of about ten clocks. A 16-bit-cycle indicator stops the fast reply, because 16-bit I/O cycles may not be shortened. In that case the block falls back to the wait-count timing.

Decisions are taken on the rising bus-clock edge, and the outputs change right after it. The host samples the outputs on the following falling edge. For every falling edge at which the host sees channel-ready low, it adds one full bus clock. The asynchronous reset input is released to the logic through a two-stage synchronizer.

Top module: `isa_wait_gen`

## Requirements
- R1: While reset is asserted, and for the clocks after its release until a selected strobe arrives, both `rdy_oe` and `nows_oe` are 0.
- R2: A cycle is selected only when all of these hold at a rising edge: `bus_addr` lies in the window `0x300`–`0x307` (bits 9:3 equal `7'h60`), `dma_aen` is 0, and `io_rd_n` or `io_wr_n` is 0. Any other combination leaves both enables at 0.
- R3: On the first selecting edge, if the fast reply does not apply and the clamped count N is greater than zero, `rdy_oe` is 1 for exactly N clock cycles starting right after that edge. `nows_oe` stays 0.
- R4: `rdy_lvl` and `nows_lvl` are 0 at all times. Only the enables vary, so neither line is ever driven high.
- R5: The wait count used is `min(cfg_waits, 10)`. A setting of 10 or more gives exactly 10 low clocks.
- R6: When `cfg_fast` is 1 and `cyc16` is 0 at the selecting edge, `nows_oe` is 1 from the next cycle until the strobe deasserts, and `rdy_oe` stays 0 for that access.
- R7: When `cyc16` is 1 at the selecting edge, `nows_oe` stays 0 even if `cfg_fast` is 1. The access follows the wait-count timing of R3 or R9 instead.
- R8: Each strobe assertion gets at most one stretch. After the count expires, `rdy_oe` stays 0 until both strobes return high, and the block re-arms only then.
- R9: With `cfg_waits` = 0 and no fast reply, a selected access leaves both enables at 0, which gives the default bus timing.
- R10: A rising edge at which both strobes are high (1) makes both enables 0 on the following cycle. This includes cutting a stretch short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | I/O address lines |
| dma_aen | input | 1 | High while DMA owns the bus; blocks decoding |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| cyc16 | input | 1 | Current cycle is a 16-bit I/O cycle |
| cfg_waits | input | 4 | Configured number of wait clocks |
| cfg_fast | input | 1 | Select the no-wait-state reply |
| rdy_oe | output | 1 | Drive-low enable for channel-ready |
| rdy_lvl | output | 1 | Level for channel-ready (always 0) |
| nows_oe | output | 1 | Drive-low enable for no-wait-state |
| nows_lvl | output | 1 | Level for no-wait-state (always 0) |

## Verification
The bench measures the exact length of each stretch at counts of 1 through 3, at the clamp boundary of 10, and above it at 11 and 15. A design that counted off by one or failed to clamp would hold the ready line low one clock too long, or long past the bus limit. The bench also fires the fast mode together with the 16-bit indicator, where a wrong design would shorten a cycle that must not be shortened. It holds strobes long after the count has expired to catch a second stretch in the same access, and it releases a strobe in the middle of a stretch to catch an enable left stuck low. Decoy addresses, DMA-owned cycles and a random phase, checked clock by clock against a behavioural model, show any reply given to a cycle that was never selected.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;

  typedef enum logic [1:0] {
    WS_IDLE    = 2'd0,
    WS_STRETCH = 2'd1,
    WS_FAST    = 2'd2,
    WS_HOLD    = 2'd3
  } ws_state_t;

endpackage

// File: rtl/isa_wait_rst_sync.sv
module isa_wait_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/isa_wait_decode.sv
module isa_wait_decode #(
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 10'h3F8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dma_aen,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              strobe,
  output logic              hit
);

  logic in_window;

  always_comb begin
    strobe    = ~rd_n | ~wr_n;
    in_window = (((addr ^ BASE_ADDR) & ADDR_MASK) == '0);
    hit       = strobe & in_window & ~dma_aen;
  end

endmodule

// File: rtl/isa_wait_counter.sv
module isa_wait_counter #(
  parameter int WS_W     = 4,
  parameter int WAIT_CAP = 10,
  localparam int CNT_W   = $clog2(WAIT_CAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WS_W-1:0] cfg_waits,
  input  logic            load,
  input  logic            dec_en,
  output logic            cfg_zero,
  output logic            last
);

  logic [CNT_W-1:0] eff_waits;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (32'(cfg_waits) > WAIT_CAP) eff_waits = CNT_W'(WAIT_CAP);
    else                           eff_waits = CNT_W'(cfg_waits);
    cfg_zero = (eff_waits == '0);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = eff_waits;
    else if (dec_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load || dec_en)  cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/isa_wait_fsm.sv
module isa_wait_fsm
  import isa_wait_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic hit,
  input  logic fast_ok,
  input  logic cfg_zero,
  input  logic last,
  output logic load,
  output logic dec_en,
  output logic rdy_oe,
  output logic nows_oe
);

  ws_state_t state_d;
  ws_state_t state_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    dec_en  = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (hit) begin
          if (fast_ok) begin
            state_d = WS_FAST;
          end else if (!cfg_zero) begin
            state_d = WS_STRETCH;
            load    = 1'b1;
          end else begin
            state_d = WS_HOLD;
          end
        end
      end
      WS_STRETCH: begin
        if (!strobe)   state_d = WS_IDLE;
        else if (last) state_d = WS_HOLD;
        else           dec_en  = 1'b1;
      end
      WS_FAST: begin
        if (!strobe) state_d = WS_IDLE;
      end
      WS_HOLD: begin
        if (!strobe) state_d = WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

  assign rdy_oe  = (state_q == WS_STRETCH);
  assign nows_oe = (state_q == WS_FAST);

endmodule

// File: rtl/isa_wait_gen.sv
module isa_wait_gen #(
  parameter int                ADDR_W    = 10,
  parameter int                WS_W      = 4,
  parameter int                WAIT_CAP  = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 10'h3F8
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              dma_aen,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  input  logic              cyc16,
  input  logic [WS_W-1:0]   cfg_waits,
  input  logic              cfg_fast,
  output logic              rdy_oe,
  output logic              rdy_lvl,
  output logic              nows_oe,
  output logic              nows_lvl
);

  logic srst_n;
  logic strobe;
  logic hit;
  logic fast_ok;
  logic cfg_zero;
  logic last;
  logic load;
  logic dec_en;

  isa_wait_rst_sync #(.STAGES(2)) u_rst (
    .clk    (bclk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  isa_wait_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .ADDR_MASK (ADDR_MASK)
  ) u_dec (
    .addr    (bus_addr),
    .dma_aen (dma_aen),
    .rd_n    (io_rd_n),
    .wr_n    (io_wr_n),
    .strobe  (strobe),
    .hit     (hit)
  );

  assign fast_ok = cfg_fast & ~cyc16;

  isa_wait_counter #(
    .WS_W     (WS_W),
    .WAIT_CAP (WAIT_CAP)
  ) u_cnt (
    .clk       (bclk),
    .rst_n     (srst_n),
    .cfg_waits (cfg_waits),
    .load      (load),
    .dec_en    (dec_en),
    .cfg_zero  (cfg_zero),
    .last      (last)
  );

  isa_wait_fsm u_fsm (
    .clk      (bclk),
    .rst_n    (srst_n),
    .strobe   (strobe),
    .hit      (hit),
    .fast_ok  (fast_ok),
    .cfg_zero (cfg_zero),
    .last     (last),
    .load     (load),
    .dec_en   (dec_en),
    .rdy_oe   (rdy_oe),
    .nows_oe  (nows_oe)
  );

  assign rdy_lvl  = 1'b0;
  assign nows_lvl = 1'b0;

endmodule

// File: rtl/isa_wait_chk.sv
module isa_wait_chk #(
  parameter int WAIT_CAP = 10
) (
  input logic bclk,
  input logic srst_n,
  input logic dma_aen,
  input logic io_rd_n,
  input logic io_wr_n,
  input logic cyc16,
  input logic rdy_oe,
  input logic nows_oe
);

  logic       strobe_on;
  logic [7:0] run_q;
  logic       done_q;

  assign strobe_on = ~io_rd_n | ~io_wr_n;

  always_ff @(posedge bclk or negedge srst_n) begin
    if (!srst_n) begin
      run_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (!rdy_oe)             run_q <= '0;
      else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
      if (!strobe_on)          done_q <= 1'b0;
      else if (rdy_oe)         done_q <= 1'b1;
    end
  end

  // R10
  release_on_idle_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    !strobe_on |=> (!rdy_oe && !nows_oe));

  // R5
  ready_cap_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    rdy_oe |-> (32'(run_q) < WAIT_CAP));

  // R7
  no_fast16_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    $rose(nows_oe) |-> !$past(cyc16));

  // R6
  one_reply_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    !(rdy_oe && nows_oe));

  // R8
  single_stretch_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    $rose(rdy_oe) |-> !done_q);

  // R2
  needs_select_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    ($rose(rdy_oe) || $rose(nows_oe)) |-> $past(strobe_on && !dma_aen));

endmodule

bind isa_wait_gen isa_wait_chk #(.WAIT_CAP(WAIT_CAP)) u_chk (
  .bclk    (bclk),
  .srst_n  (srst_n),
  .dma_aen (dma_aen),
  .io_rd_n (io_rd_n),
  .io_wr_n (io_wr_n),
  .cyc16   (cyc16),
  .rdy_oe  (rdy_oe),
  .nows_oe (nows_oe)
);

// File: tb/tb_isa_wait_gen.sv
`timescale 1ns/1ps
module tb_isa_wait_gen;

  logic       bclk;
  logic       rst_n;
  logic [9:0] bus_addr;
  logic       dma_aen;
  logic       io_rd_n;
  logic       io_wr_n;
  logic       cyc16;
  logic [3:0] cfg_waits;
  logic       cfg_fast;
  logic       rdy_oe;
  logic       rdy_lvl;
  logic       nows_oe;
  logic       nows_lvl;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // behavioural reference state
  bit m_armed  = 1;
  bit m_fast   = 0;
  int m_left   = 0;
  bit cmp_on   = 0;

  isa_wait_gen dut (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .dma_aen   (dma_aen),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .cyc16     (cyc16),
    .cfg_waits (cfg_waits),
    .cfg_fast  (cfg_fast),
    .rdy_oe    (rdy_oe),
    .rdy_lvl   (rdy_lvl),
    .nows_oe   (nows_oe),
    .nows_lvl  (nows_lvl)
  );

  initial bclk = 0;
  always #5 bclk = ~bclk;

  function automatic bit in_win(input logic [9:0] a);
    return a[9:3] == 7'h60;
  endfunction

  function automatic int clamp10(input int v);
    return (v > 10) ? 10 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge bclk) begin
    bit str;
    bit sel;
    cycles++;
    str = !io_rd_n || !io_wr_n;
    sel = str && !dma_aen && in_win(bus_addr);
    if (!rst_n) begin
      m_armed = 1; m_fast = 0; m_left = 0;
    end else if (!str) begin
      m_armed = 1; m_fast = 0; m_left = 0;
    end else if (m_armed && sel) begin
      m_armed = 0;
      if (cfg_fast && !cyc16) m_fast = 1;
      else                    m_left = clamp10(int'(cfg_waits));
    end else if (m_left > 0) begin
      m_left--;
    end
  end

  // clock-by-clock comparison away from the active edge
  always @(negedge bclk) begin
    if (cmp_on) begin
      check(rdy_oe == (m_left > 0), "R3 rdy_oe vs model", int'(rdy_oe), int'(m_left > 0));
      check(nows_oe == m_fast, "R6 nows_oe vs model", int'(nows_oe), int'(m_fast));
      check(rdy_lvl == 1'b0 && nows_lvl == 1'b0, "R4 levels low",
            int'({rdy_lvl, nows_lvl}), 0);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge bclk);
  endtask

  task automatic access(input logic [9:0] a, input bit is_wr, input bit aen_v,
                        input bit c16, input int hold,
                        output int n_rdy, output int n_nows);
    n_rdy = 0; n_nows = 0;
    @(negedge bclk);
    bus_addr = a; dma_aen = aen_v; cyc16 = c16;
    if (is_wr) io_wr_n = 0; else io_rd_n = 0;
    for (int i = 0; i < hold; i++) begin
      @(posedge bclk);
      @(negedge bclk);
      if (rdy_oe)  n_rdy++;
      if (nows_oe) n_nows++;
    end
    io_rd_n = 1; io_wr_n = 1;
    @(posedge bclk);
    @(negedge bclk);
    check(!rdy_oe && !nows_oe, "R10 released after strobe", int'({rdy_oe, nows_oe}), 0);
    dma_aen = 0; cyc16 = 0;
    idle(2);
  endtask

  initial begin : watchdog
    #(10 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    int nr, nn;
    rst_n = 0; bus_addr = 10'h000; dma_aen = 0; io_rd_n = 1; io_wr_n = 1;
    cyc16 = 0; cfg_waits = 4'd0; cfg_fast = 0;
    idle(3);
    check(!rdy_oe && !nows_oe, "R1 enables in reset", int'({rdy_oe, nows_oe}), 0);
    check(rdy_lvl == 0 && nows_lvl == 0, "R4 levels in reset", int'({rdy_lvl, nows_lvl}), 0);
    rst_n = 1;
    idle(4);
    check(!rdy_oe && !nows_oe, "R1 enables after reset", int'({rdy_oe, nows_oe}), 0);
    cmp_on = 1;

    cfg_waits = 4'd3;
    access(10'h300, 0, 0, 0, 8, nr, nn);
    check(nr == 3, "R3 read stretch of 3", nr, 3);
    check(nn == 0, "R3 no fast reply", nn, 0);
    access(10'h307, 1, 0, 0, 8, nr, nn);
    check(nr == 3, "R2 write strobe stretch", nr, 3);

    cfg_waits = 4'd1;
    access(10'h304, 0, 0, 0, 4, nr, nn);
    check(nr == 1, "R3 stretch of 1", nr, 1);

    cfg_waits = 4'd10;
    access(10'h301, 0, 0, 0, 14, nr, nn);
    check(nr == 10, "R5 count at cap", nr, 10);
    cfg_waits = 4'd11;
    access(10'h301, 0, 0, 0, 14, nr, nn);
    check(nr == 10, "R5 count 11 clamped", nr, 10);
    cfg_waits = 4'd15;
    access(10'h302, 1, 0, 0, 16, nr, nn);
    check(nr == 10, "R5 count 15 clamped", nr, 10);

    cfg_waits = 4'd0;
    access(10'h300, 0, 0, 0, 6, nr, nn);
    check(nr == 0 && nn == 0, "R9 zero count default timing", nr + nn, 0);

    cfg_waits = 4'd4;
    access(10'h308, 0, 0, 0, 6, nr, nn);
    check(nr == 0 && nn == 0, "R2 address outside window", nr + nn, 0);
    access(10'h2FF, 1, 0, 0, 6, nr, nn);
    check(nr == 0 && nn == 0, "R2 address below window", nr + nn, 0);
    access(10'h303, 0, 1, 0, 6, nr, nn);
    check(nr == 0 && nn == 0, "R2 DMA cycle ignored", nr + nn, 0);

    cfg_fast = 1; cfg_waits = 4'd5;
    access(10'h305, 0, 0, 0, 5, nr, nn);
    check(nn == 5, "R6 fast reply held", nn, 5);
    check(nr == 0, "R6 no stretch in fast", nr, 0);
    cfg_waits = 4'd2;
    access(10'h305, 0, 0, 1, 6, nr, nn);
    check(nn == 0, "R7 no fast on 16-bit", nn, 0);
    check(nr == 2, "R7 fallback stretch", nr, 2);
    cfg_waits = 4'd0;
    access(10'h306, 1, 0, 1, 5, nr, nn);
    check(nr == 0 && nn == 0, "R7 fallback default timing", nr + nn, 0);
    cfg_fast = 0;

    cfg_waits = 4'd8;
    access(10'h300, 0, 0, 0, 3, nr, nn);
    check(nr == 3, "R10 stretch cut by strobe release", nr, 3);

    cfg_waits = 4'd2;
    access(10'h300, 0, 0, 0, 10, nr, nn);
    check(nr == 2, "R8 one stretch per strobe", nr, 2);
    access(10'h300, 0, 0, 0, 10, nr, nn);
    check(nr == 2, "R8 re-armed after release", nr, 2);

    // random phase, checked by the model every clock
    for (int i = 0; i < 600; i++) begin
      @(negedge bclk);
      bus_addr  = ($urandom_range(0, 3) == 0) ? 10'h310 : (10'h300 + 10'($urandom_range(0, 7)));
      dma_aen   = ($urandom_range(0, 7) == 0);
      cyc16     = $urandom_range(0, 1) == 1;
      io_rd_n   = ($urandom_range(0, 9) < 3);
      io_wr_n   = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 15) == 0) begin
        cfg_waits = 4'($urandom_range(0, 15));
        cfg_fast  = $urandom_range(0, 1) == 1;
      end
    end
    io_rd_n = 1; io_wr_n = 1;
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule